// File: doc/BRIEF.md
# Condition Code Register and Flag Unit

This block keeps the eight-bit processor status byte and produces the arithmetic flags for eight-bit addition, subtraction and comparison. The byte is laid out from bit 7 down to bit 0 as stop-disable (S), non-maskable interrupt mask (X), half carry (H), maskable interrupt mask (I), negative (N), zero (Z), overflow (V) and carry (C). The surrounding core supplies the two operands, an operation code and four single-cycle control strobes. In return it takes the arithmetic result and a write-back enable for the accumulator in the same cycle, and the updated status byte after the next rising clock edge.

Comparison performs the subtraction only to set the flags and keeps the accumulator unchanged. Only addition updates the half-carry flag. The X mask works in one direction only: a strobe can clear it, and only reset can set it again. The S bit is also brought out as an inverted stop-allowed qualifier.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is asserted and after it is released, the status byte reads 0xD0 (S, X and I at 1, every other bit 0), and stop_allowed is 0.
- R2: With op_sel = 1 (add), result is the eight-bit sum of opnd_a and opnd_m in the same cycle and acc_we is 1. After the next rising edge, C (bit 0) holds the carry out of bit 7 and H (bit 5) holds the carry out of bit 3.
- R3: With op_sel = 2 (subtract) or op_sel = 3 (compare), result is opnd_a minus opnd_m and C holds the borrow out of bit 7. H keeps its previous value.
- R4: After any add, subtract or compare, N (bit 3) equals bit 7 of the result and Z (bit 2) is 1 exactly when the eight-bit result is zero.
- R5: V (bit 1) is set after addition when both operands have the same sign and the sign of the result differs from them. It is set after subtraction or compare when the operands differ in sign and the sign of the result differs from the sign of opnd_a. Otherwise V is cleared.
- R6: Compare drives acc_we to 0. Subtract drives acc_we to 1.
- R7: With op_sel = 0 (no operation), acc_we is 0 and H, N, Z, V and C keep their values.
- R8: A clr_xmask pulse clears X (bit 6). After that, no strobe or operation sets X again, and only reset returns it to 1.
- R9: clr_imask clears I (bit 4) and set_imask sets it. If both strobes are high in the same cycle, I ends up 1.
- R10: clr_stop clears S (bit 7), and after that stop_allowed reads 1. No strobe sets S again, and only reset returns it to 1.
- R11: ALU operations never change S, X or I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status byte changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset to the power-on status |
| op_sel | input | 2 | 0 none, 1 add, 2 subtract, 3 compare |
| opnd_a | input | 8 | Accumulator operand (minuend for subtract and compare) |
| opnd_m | input | 8 | Memory operand (subtrahend for subtract and compare) |
| set_imask | input | 1 | Sets the maskable interrupt mask |
| clr_imask | input | 1 | Clears the maskable interrupt mask |
| clr_xmask | input | 1 | Clears the non-maskable interrupt mask (one way only) |
| clr_stop | input | 1 | Clears the stop-disable bit |
| result | output | 8 | Arithmetic result for the current operation |
| acc_we | output | 1 | Accumulator write-back enable |
| ccr | output | 8 | Status byte S X H I N Z V C, bit 7 to bit 0 |
| stop_allowed | output | 1 | High when S is 0 |

## Verification
The bench runs a chain of operations in which subtractions and compares come after additions that left H set and after additions that left H clear. A design that let subtraction drive H would break that chain. The chain also includes overflow at both sign boundaries (0x7F plus 0x01, and 0x80 minus 0x01) and mixed-sign compares, which expose a V rule that looks at the wrong operand's sign. The bench applies a compare whose result differs from opnd_a, so a design that writes back on compare would show acc_we high. Further tests try to set X again after clearing it, raise set and clear of I in the same cycle, and place a no-operation cycle between arithmetic steps, where a design would wrongly recompute flags.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_CMP  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } aflags_t;

    localparam ccr_t CCR_POR = '{s: 1'b1, x: 1'b1, h: 1'b0, i: 1'b1,
                                 n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
    import ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         is_add_i,
    output logic [W-1:0] res_o,
    output aflags_t      flg_o
);
    localparam int HB = W / 2;

    logic [W:0]  sum_w;
    logic [W:0]  dif_w;
    logic [HB:0] low_sum_w;
    logic        sa, sm, sr;

    always_comb begin
        sum_w     = {1'b0, a_i} + {1'b0, m_i};
        dif_w     = {1'b0, a_i} - {1'b0, m_i};
        low_sum_w = {1'b0, a_i[HB-1:0]} + {1'b0, m_i[HB-1:0]};
        res_o     = is_add_i ? sum_w[W-1:0] : dif_w[W-1:0];
        sa        = a_i[W-1];
        sm        = m_i[W-1];
        sr        = res_o[W-1];
        flg_o.h   = low_sum_w[HB];
        flg_o.c   = is_add_i ? sum_w[W] : dif_w[W];
        flg_o.n   = sr;
        flg_o.z   = (res_o == '0);
        flg_o.v   = is_add_i ? ((sa == sm) && (sr != sa))
                             : ((sa != sm) && (sr != sa));
    end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
    import ccr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd_arith_i,
    input  logic    upd_h_i,
    input  aflags_t flg_i,
    input  logic    set_i_i,
    input  logic    clr_i_i,
    input  logic    clr_x_i,
    input  logic    clr_s_i,
    output ccr_t    ccr_q
);
    ccr_t ccr_d;

    always_comb begin
        ccr_d = ccr_q;
        if (upd_arith_i) begin
            ccr_d.n = flg_i.n;
            ccr_d.z = flg_i.z;
            ccr_d.v = flg_i.v;
            ccr_d.c = flg_i.c;
        end
        if (upd_h_i) ccr_d.h = flg_i.h;
        if (clr_i_i) ccr_d.i = 1'b0;
        if (set_i_i) ccr_d.i = 1'b1;
        if (clr_x_i) ccr_d.x = 1'b0;
        if (clr_s_i) ccr_d.s = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CCR_POR;
        else        ccr_q <= ccr_d;
    end

    assert_x_oneway_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_q.x |=> !ccr_q.x);

    assert_s_oneway_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_q.s |=> !ccr_q.s);

    assert_iset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i_i |=> ccr_q.i);
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_m,
    input  logic         set_imask,
    input  logic         clr_imask,
    input  logic         clr_xmask,
    input  logic         clr_stop,
    output logic [W-1:0] result,
    output logic         acc_we,
    output logic [7:0]   ccr,
    output logic         stop_allowed
);
    alu_op_e op_w;
    aflags_t flg_w;
    ccr_t    ccr_w;
    logic    is_add_w;
    logic    active_w;

    always_comb begin
        op_w     = alu_op_e'(op_sel);
        is_add_w = (op_w == OP_ADD);
        active_w = (op_w != OP_NONE);
        acc_we   = (op_w == OP_ADD) || (op_w == OP_SUB);
    end

    ccr_alu #(.W(W)) u_alu (
        .a_i      (opnd_a),
        .m_i      (opnd_m),
        .is_add_i (is_add_w),
        .res_o    (result),
        .flg_o    (flg_w)
    );

    ccr_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_arith_i (active_w),
        .upd_h_i     (is_add_w),
        .flg_i       (flg_w),
        .set_i_i     (set_imask),
        .clr_i_i     (clr_imask),
        .clr_x_i     (clr_xmask),
        .clr_s_i     (clr_stop),
        .ccr_q       (ccr_w)
    );

    always_comb begin
        ccr          = ccr_w;
        stop_allowed = ~ccr_w.s;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0) |=> ($stable(ccr[5]) && $stable(ccr[3:0])));

    assert_h_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[1]) |=> $stable(ccr[5]));

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 2'd0) |=> (ccr[2] == ($past(result) == '0)));

    assert_cmp_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd3) |-> !acc_we);
endmodule

// File: tb/ccr_flag_unit_test.sv
module ccr_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] op_sel;
    logic [7:0] opnd_a, opnd_m;
    logic       set_imask, clr_imask, clr_xmask, clr_stop;
    logic [7:0] result;
    logic       acc_we;
    logic [7:0] ccr;
    logic       stop_allowed;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ccr_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_m(opnd_m),
        .set_imask(set_imask), .clr_imask(clr_imask), .clr_xmask(clr_xmask),
        .clr_stop(clr_stop), .result(result), .acc_we(acc_we), .ccr(ccr),
        .stop_allowed(stop_allowed)
    );

    // row: op(2) a(8) m(8) result(8) we(1) {H,N,Z,V,C}(5); op 0 rows skip result
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {2'd1, 8'h38, 8'hA9, 8'hE1, 1'b1, 5'b11000},
        {2'd1, 8'h9A, 8'hA9, 8'h43, 1'b1, 5'b10011},
        {2'd2, 8'h70, 8'h80, 8'hF0, 1'b1, 5'b11011},
        {2'd1, 8'hFC, 8'h04, 8'h00, 1'b1, 5'b10101},
        {2'd3, 8'hE2, 8'hE2, 8'h00, 1'b0, 5'b10100},
        {2'd1, 8'h01, 8'h02, 8'h03, 1'b1, 5'b00000},
        {2'd2, 8'hFC, 8'h04, 8'hF8, 1'b1, 5'b01000},
        {2'd1, 8'h7F, 8'h01, 8'h80, 1'b1, 5'b11010},
        {2'd3, 8'h80, 8'h70, 8'h10, 1'b0, 5'b10010},
        {2'd2, 8'h00, 8'h01, 8'hFF, 1'b1, 5'b11001},
        {2'd0, 8'h55, 8'hAA, 8'h00, 1'b0, 5'b11001},
        {2'd2, 8'h80, 8'h01, 8'h7F, 1'b1, 5'b10010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_sel = 2'd0; set_imask = 0; clr_imask = 0; clr_xmask = 0; clr_stop = 0;
    endtask

    task automatic strobe(input logic si, input logic ci, input logic cx, input logic cs);
        @(negedge clk);
        set_imask = si; clr_imask = ci; clr_xmask = cx; clr_stop = cs;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        opnd_a = 0; opnd_m = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 reset ccr", ccr, 8'hD0);
        chk("R1 stop_allowed", stop_allowed, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", ccr, 8'hD0);

        for (int k = 0; k < NV; k++) begin
            logic [31:0] r;
            r = VEC[k];
            @(negedge clk);
            op_sel = r[31:30]; opnd_a = r[29:22]; opnd_m = r[21:14];
            #2;
            if (r[31:30] != 2'd0) chk("R2 R3 result", result, r[13:6]);
            chk("R6 R7 acc_we", acc_we, r[5]);
            @(posedge clk); #2;
            op_sel = 2'd0;
            chk("R2 R3 R4 R5 R7 flags", {ccr[5], ccr[3:0]}, r[4:0]);
        end
        // R11: S, X, I untouched by arithmetic
        chk("R11 control bits", {ccr[7:6], ccr[4]}, 3'b111);

        // R9
        strobe(0, 1, 0, 0);
        chk("R9 clear I", ccr[4], 1'b0);
        strobe(1, 0, 0, 0);
        chk("R9 set I", ccr[4], 1'b1);
        strobe(0, 1, 0, 0);
        strobe(1, 1, 0, 0);
        chk("R9 set wins", ccr[4], 1'b1);

        // R8
        strobe(0, 0, 1, 0);
        chk("R8 clear X", ccr[6], 1'b0);
        strobe(1, 0, 0, 0);
        @(negedge clk); op_sel = 2'd1; opnd_a = 8'hFF; opnd_m = 8'hFF;
        @(negedge clk); idle();
        chk("R8 X stays clear", ccr[6], 1'b0);

        // R10
        chk("R10 stop blocked", stop_allowed, 1'b0);
        strobe(0, 0, 0, 1);
        chk("R10 clear S", ccr[7], 1'b0);
        chk("R10 stop allowed", stop_allowed, 1'b1);
        strobe(1, 0, 0, 0);
        chk("R10 S stays clear", ccr[7], 1'b0);

        // R1 again: reset restores masks
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R1 re-reset", ccr, 8'hD0);
        chk("R8 X back via reset", ccr[6], 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule